// File: doc/BRIEF.md
# Key-Gated Configuration Window Decoder

This block decodes host I/O port accesses for a configuration access scheme in which the function number and a key nibble live in a byte-wide enable register. The bus number lives in a separate bus-forward register. When the upper nibble of the enable register holds the key value 0xF, a 4 KB I/O window at ports 0xC000 to 0xCFFF is open. Any access that lands inside it becomes a configuration request. The port address carries the device number in bits 11:8 and the register offset in bits 7:0.

The I/O side is a single-cycle port: a valid strobe, a write flag, a 16-bit port address, a size code and a 32-bit lane-aligned data bus. The byte at port `p` travels in lane `p[1:0]`. Each request is issued combinationally in the cycle of the access, and its read data is returned in that same cycle. Register writes take effect at the following clock edge.

Top module: `cfg_keywin_dec`

## Requirements
- R1: After reset both the enable register and the forward register read as 0x00, and window accesses produce no request.
- R2: An aligned write covering port 0xCF8 stores the whole byte from lane 0 (bits 7:0), including bit 0. A read of that port returns it in lane 0.
- R3: An aligned write covering port 0xCFA stores the bus number from lane 2 (bits 23:16). A read returns it in lane 2. Within a read of the 0xCF8 dword, lanes 1 and 3 read 0xFF.
- R4: With the key nibble (enable bits 7:4) at 0xF, an aligned access to 0xC000 to 0xCFFF raises `cfg_req` and sets `io_claim`. The request carries bus = forward register, function = enable bits 3:1, device = address bits 11:8 and dword index = address bits 7:2.
- R5: With the key nibble at any other value, window accesses raise no request and reads return 0xFFFFFFFF. The same all-ones value is returned for any read the block does not claim.
- R6: The size code is 0 for a byte, 1 for a word and 2 for a dword. Byte enables are 0001 shifted by address bits 1:0 for a byte, 0011 shifted by address bits 1:0 for a word, and 1111 for a dword.
- R7: Misaligned accesses are ignored: a word at an odd address, a dword whose address bits 1:0 are not 00, or size code 3. Such an access raises no request, sets no claim, reads all ones and updates no register.
- R8: Writing zero to the enable register closes the window. After zero is written to both 0xCF8 and 0xCFA, both read back zero.
- R9: Enable bit 0 has no effect on decoding or on any request field.
- R10: `cfg_write` follows `io_write` and `cfg_wdata` equals `io_wdata` for a request. A window read returns `cfg_rdata` on `io_rdata`.
- R11: Ports outside 0xC000 to 0xCFFF never raise a request. Only 16 devices (0 to 15) are reachable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | I/O access strobe, one cycle per access |
| io_write | input | 1 | 1 = write, 0 = read |
| io_addr | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 invalid |
| io_wdata | input | 32 | Lane-aligned write data |
| io_rdata | output | 32 | Lane-aligned read data, valid in the access cycle |
| io_claim | output | 1 | Access decoded by this block |
| cfg_req | output | 1 | Configuration request |
| cfg_write | output | 1 | Request is a write |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 4 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_dwi | output | 6 | Register dword index |
| cfg_be | output | 4 | Byte enables |
| cfg_wdata | output | 32 | Write data |
| cfg_rdata | input | 32 | Read data from the configuration target |

## Verification
The hardest situations to reach are accesses whose meaning depends on register state built up by earlier accesses. One case is a window access made after the key nibble has been set to a near-miss value such as 0xE or 0x7. Another is a pair of keys that differ only in bit 0. Getting there requires a sequence of enable and forward writes before each window probe. The bench therefore keeps its own model of both registers, updated from the requirements, and predicts every request field and read value from it. Misaligned and invalid-size accesses are interleaved with register writes so that an ignored write is seen to leave the state untouched.

// File: rtl/cfg_keywin_dec.sv
module cfg_keywin_dec #(
  parameter logic [15:0] REG_PORT = 16'hCF8,
  parameter logic [3:0]  WIN_NIB  = 4'hC,
  parameter logic [3:0]  KEY      = 4'hF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_valid,
  input  logic        io_write,
  input  logic [15:0] io_addr,
  input  logic [1:0]  io_size,
  input  logic [31:0] io_wdata,
  output logic [31:0] io_rdata,
  output logic        io_claim,
  output logic        cfg_req,
  output logic        cfg_write,
  output logic [7:0]  cfg_bus,
  output logic [3:0]  cfg_dev,
  output logic [2:0]  cfg_func,
  output logic [5:0]  cfg_dwi,
  output logic [3:0]  cfg_be,
  output logic [31:0] cfg_wdata,
  input  logic [31:0] cfg_rdata
);
  logic [7:0] en_q, fwd_q;
  logic [3:0] be;
  logic       aligned, reg_hit, win_hit;

  always_comb begin
    be = 4'b0000;
    aligned = 1'b0;
    unique case (io_size)
      2'd0: begin be = 4'b0001 << io_addr[1:0]; aligned = 1'b1; end
      2'd1: begin be = 4'b0011 << io_addr[1:0]; aligned = ~io_addr[0]; end
      2'd2: begin be = 4'b1111; aligned = (io_addr[1:0] == 2'b00); end
      default: begin be = 4'b0000; aligned = 1'b0; end
    endcase
  end

  assign reg_hit = io_valid && aligned && (io_addr[15:2] == REG_PORT[15:2]) && (be[0] || be[2]);
  assign win_hit = io_valid && aligned && (io_addr[15:12] == WIN_NIB) && (en_q[7:4] == KEY);

  assign io_claim  = reg_hit || win_hit;
  assign cfg_req   = win_hit;
  assign cfg_write = io_write;
  assign cfg_bus   = fwd_q;
  assign cfg_dev   = io_addr[11:8];
  assign cfg_func  = en_q[3:1];
  assign cfg_dwi   = io_addr[7:2];
  assign cfg_be    = be;
  assign cfg_wdata = io_wdata;

  assign io_rdata = reg_hit ? {8'hFF, fwd_q, 8'hFF, en_q} :
                    win_hit ? cfg_rdata : 32'hFFFF_FFFF;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= 8'h00;
      fwd_q <= 8'h00;
    end else if (reg_hit && io_write) begin
      if (be[0]) en_q  <= io_wdata[7:0];
      if (be[2]) fwd_q <= io_wdata[23:16];
    end
  end
endmodule

// File: rtl/cfg_keywin_dec_chk.sv
module cfg_keywin_dec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        io_valid,
  input logic        io_write,
  input logic [15:0] io_addr,
  input logic [1:0]  io_size,
  input logic [31:0] io_wdata,
  input logic [31:0] io_rdata,
  input logic        io_claim,
  input logic        cfg_req,
  input logic [3:0]  cfg_be
);
  p_req_in_window_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (io_valid && io_addr[15:12] == 4'hC));

  p_be_shape_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 || $countones(cfg_be) == 4));

  p_unclaimed_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && !io_write && !io_claim) |-> (io_rdata == 32'hFFFF_FFFF));

  p_zero_closes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_write && io_size == 2'd0 && io_addr == 16'hCF8 && io_wdata[7:0] == 8'h00)
    |=> !cfg_req);

  p_bad_size_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_valid && io_size == 2'd3) |-> (!io_claim && !cfg_req));

  p_req_claims_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> io_claim);
endmodule

bind cfg_keywin_dec cfg_keywin_dec_chk u_chk (.*);

// File: tb/sim_cfg_keywin_dec.sv
module sim_cfg_keywin_dec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_valid = 1'b0, io_write = 1'b0;
  logic [15:0] io_addr = '0;
  logic [1:0]  io_size = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata, cfg_wdata;
  logic io_claim, cfg_req, cfg_write;
  logic [7:0] cfg_bus;
  logic [3:0] cfg_dev, cfg_be;
  logic [2:0] cfg_func;
  logic [5:0] cfg_dwi;
  logic [31:0] cfg_rdata = 32'h1234_5678;

  always #5 clk = ~clk;

  cfg_keywin_dec u0 (.*);

  typedef struct {
    string tag;
    logic wr, req, claim;
    logic [3:0] be, dev;
    logic [7:0] bus;
    logic [2:0] func;
    logic [5:0] dwi;
    logic [31:0] wdata, rdata;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0;
  logic [7:0] m_en = 8'h00, m_fwd = 8'h00;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_io(string tag, logic wr, logic [15:0] a, logic [1:0] sz, logic [31:0] wd);
    item_t it;
    logic al;
    logic [3:0] be;
    logic rh, wh;
    @(negedge clk);
    io_valid = 1'b1; io_write = wr; io_addr = a; io_size = sz; io_wdata = wd;
    case (sz)
      2'd0: begin be = 4'b0001 << a[1:0]; al = 1'b1; end
      2'd1: begin be = 4'b0011 << a[1:0]; al = !a[0]; end
      2'd2: begin be = 4'hF; al = (a[1:0] == 2'b00); end
      default: begin be = 4'h0; al = 1'b0; end
    endcase
    rh = al && (a[15:2] == 14'h33E) && (be[0] || be[2]);
    wh = al && (a[15:12] == 4'hC) && (m_en[7:4] == 4'hF);
    it.tag = tag; it.wr = wr; it.req = wh; it.claim = rh || wh;
    it.be = be; it.dev = a[11:8]; it.bus = m_fwd; it.func = m_en[3:1];
    it.dwi = a[7:2]; it.wdata = wd;
    it.rdata = rh ? {8'hFF, m_fwd, 8'hFF, m_en} : (wh ? cfg_rdata : 32'hFFFF_FFFF);
    q.push_back(it);
    if (wr && rh) begin
      if (be[0]) m_en = wd[7:0];
      if (be[2]) m_fwd = wd[23:16];
    end
  endtask

  task automatic idle();
    @(negedge clk);
    io_valid = 1'b0; io_write = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #4;
      if (io_valid && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        chk(e.tag, "claim", {31'b0, io_claim}, {31'b0, e.claim});
        chk(e.tag, "req", {31'b0, cfg_req}, {31'b0, e.req});
        if (e.req) begin
          chk(e.tag, "bus", {24'b0, cfg_bus}, {24'b0, e.bus});
          chk(e.tag, "dev", {28'b0, cfg_dev}, {28'b0, e.dev});
          chk(e.tag, "func", {29'b0, cfg_func}, {29'b0, e.func});
          chk(e.tag, "dwi", {26'b0, cfg_dwi}, {26'b0, e.dwi});
          chk(e.tag, "be", {28'b0, cfg_be}, {28'b0, e.be});
          chk("R10", "write", {31'b0, cfg_write}, {31'b0, e.wr});
          if (e.wr) chk("R10", "wdata", cfg_wdata, e.wdata);
        end
        if (!e.wr) chk(e.tag, "rdata", io_rdata, e.rdata);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    do_io("R1", 0, 16'hCF8, 2'd2, 0);
    do_io("R1", 0, 16'hC000, 2'd2, 0);
    do_io("R3", 1, 16'hCFA, 2'd0, 32'h0007_0000);
    do_io("R3", 0, 16'hCFA, 2'd0, 0);
    do_io("R2", 1, 16'hCF8, 2'd0, 32'h0000_00F5);
    do_io("R2", 0, 16'hCF8, 2'd0, 0);
    do_io("R4", 0, 16'hC310, 2'd2, 0);
    do_io("R6", 0, 16'hC313, 2'd0, 0);
    do_io("R6", 1, 16'hCA06, 2'd1, 32'hBEEF_0000);
    do_io("R6", 1, 16'hCFFC, 2'd2, 32'hCAFE_F00D);
    do_io("R6", 0, 16'hC501, 2'd0, 0);
    do_io("R7", 0, 16'hC001, 2'd1, 0);
    do_io("R7", 0, 16'hC002, 2'd2, 0);
    do_io("R7", 0, 16'hC000, 2'd3, 0);
    do_io("R7", 1, 16'hCF9, 2'd1, 32'h0000_0000);
    do_io("R7", 0, 16'hCF8, 2'd2, 0);
    do_io("R11", 0, 16'hB000, 2'd2, 0);
    do_io("R11", 1, 16'hD0FC, 2'd2, 32'h1);
    do_io("R11", 0, 16'hCF04, 2'd2, 0);
    do_io("R3", 1, 16'hCF8, 2'd2, 32'h0011_00F0);
    do_io("R9", 0, 16'hC204, 2'd2, 0);
    do_io("R9", 1, 16'hCF8, 2'd0, 32'h0000_00F1);
    do_io("R9", 0, 16'hC204, 2'd2, 0);
    do_io("R5", 1, 16'hCF8, 2'd0, 32'h0000_00E4);
    do_io("R5", 0, 16'hC204, 2'd2, 0);
    do_io("R5", 1, 16'hCF8, 2'd0, 32'h0000_007F);
    do_io("R5", 0, 16'hC800, 2'd0, 0);
    do_io("R5", 0, 16'hCF8, 2'd0, 0);
    do_io("R10", 1, 16'hCF8, 2'd0, 32'h0000_00FE);
    do_io("R10", 0, 16'hC7F8, 2'd2, 0);
    do_io("R8", 1, 16'hCF8, 2'd0, 32'h0);
    do_io("R8", 1, 16'hCFA, 2'd0, 32'h0);
    do_io("R8", 0, 16'hCF8, 2'd0, 0);
    do_io("R8", 0, 16'hCFA, 2'd0, 0);
    do_io("R8", 0, 16'hC000, 2'd2, 0);
    idle();
    repeat (3) @(negedge clk);
    if (q.size() != 0) chk("R4", "queue", q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule